// File: doc/BRIEF.md
# Mailbox Flash Programming Controller

This block lets a CPU program and erase a two-bank on-chip flash through a small set of mailbox registers. Software first sets the target address, the data byte and the configuration. It then writes an operation code to the command register, and that write is the only event that starts work. The bank that is modified is never the one the CPU is fetching code from. Code running from the main bank always changes the secondary bank, and code running from the secondary bank always changes the main bank. Code running from external memory changes whichever bank its address selects, given the current overlay setting.

A running operation holds the busy flag for a fixed number of cycles, and that number depends on the operation. Software can poll the flag. It can also ask for an interrupt by setting the top bit of the command byte. In that mode the controller takes over the shared interrupt line, and the external interrupt pin no longer reaches it. Per-bank lock inputs and a global enable bit gate every command. A read port gives the CPU access to both banks. A read from the bank under operation reports a failure.

The flash model is a register array with fixed latencies. The mailbox is a plain register interface with no streaming data path, so there is no back-pressure.

Top module: `iap_flash_ctrl`

## Requirements
- R1: While the enable bit (configuration register, offset 4, bit 7) is 0, every command write is ignored: the busy flag stays low and no flash byte changes.
- R2: Writes to the address-low (offset 1), address-high (offset 2), data (offset 3), configuration (offset 4) and status (offset 5) registers never start an operation. Only a write to offset 0 does.
- R3: A command whose resolved target bank has its lock input high is ignored.
- R4: With the execution source set to main (exec_src = 0), the target is the secondary bank. With the source set to secondary (exec_src = 1), the target is the main bank.
- R5: With the source set to external (exec_src = 2 or 3), the target is the secondary bank exactly when the overlay bit (configuration bit 0) is 1 and the 16-bit mailbox address is below SEC_BYTES. Otherwise the target is the main bank.
- R6: An accepted command holds the busy flag (status bit 0 and pin flash_busy) high for exactly PROG_LAT, SECT_LAT or BLK_LAT cycles, for the program, sector-erase and bank-erase operations respectively. The flag is then 0 again.
- R7: Program (command bits 6:0 = 1) replaces the target byte with the bitwise AND of the old byte and the data register, so a program can only clear bits.
- R8: Sector erase (code 2) sets the SECTOR-byte aligned sector that holds the address to FFh. Bank erase (code 3) sets the whole target bank to FFh. Bytes outside the erased range keep their values.
- R9: Command bit 7 of the most recently accepted command selects interrupt mode. In interrupt mode, int1_out is 0 except for a single one-cycle pulse in the cycle after busy falls, and ext_int_pin is ignored. Otherwise int1_out equals ext_int_pin.
- R10: While busy, a read of the target bank gives rd_fail = 1 and rd_data = 00h. A read of the other bank returns its stored byte with rd_fail = 0.
- R11: A command write while busy is ignored and sets the sticky error flag (status bit 1). Writing status with bit 1 set clears the flag.
- R12: Command codes other than 1, 2 and 3 in bits 6:0 are ignored.
- R13: After reset, every register reads 0, busy is 0 and every flash byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Mailbox register write strobe |
| reg_addr | input | 3 | Mailbox register offset |
| reg_wdata | input | 8 | Mailbox write data |
| reg_rdata | output | 8 | Mailbox read data for reg_addr |
| exec_src | input | 2 | Where code executes: 0 main, 1 secondary, 2/3 external |
| lock_main | input | 1 | Lock for the main bank |
| lock_sec | input | 1 | Lock for the secondary bank |
| ext_int_pin | input | 1 | External interrupt pin |
| int1_out | output | 1 | Shared interrupt line |
| flash_busy | output | 1 | Operation in progress |
| rd_sel_sec | input | 1 | Read port bank select, 1 = secondary |
| rd_addr | input | log2(MAIN_BYTES) | Read port byte address |
| rd_data | output | 8 | Read data |
| rd_fail | output | 1 | Read refused because the bank is busy |

## Verification
A wrong target decision shows up as soon as the operation finishes. The wrong bank's bytes change, and reads of the bank under operation fail or succeed when they should not. A counter error in the operation timer shows within one cycle of the expected end, as a busy flag that falls too early or too late. A stale interrupt-mode flag shows on the first cycle the external pin is driven, because int1_out then follows the pin when it should hold low, or the other way round. The bench compares busy and the interrupt line with its own model on every cycle, and it reads the flash contents back at chosen points.

// File: rtl/iap_pkg.sv
package iap_pkg;
  localparam logic [6:0] OP_PROG  = 7'd1;
  localparam logic [6:0] OP_SERA  = 7'd2;
  localparam logic [6:0] OP_BERA  = 7'd3;
  localparam logic [2:0] RA_CMD   = 3'd0;
  localparam logic [2:0] RA_ALO   = 3'd1;
  localparam logic [2:0] RA_AHI   = 3'd2;
  localparam logic [2:0] RA_DAT   = 3'd3;
  localparam logic [2:0] RA_CFG   = 3'd4;
  localparam logic [2:0] RA_STAT  = 3'd5;
  typedef enum logic [1:0] {K_PROG = 2'd1, K_SERA = 2'd2, K_BERA = 2'd3} op_kind_e;
endpackage

// File: rtl/iap_target_resolve.sv
module iap_target_resolve #(
  parameter int SEC_BYTES = 64
) (
  input  logic [1:0]  src,
  input  logic        overlay,
  input  logic [15:0] addr,
  output logic        tgt_sec
);
  always_comb begin
    case (src)
      2'd0:    tgt_sec = 1'b1;
      2'd1:    tgt_sec = 1'b0;
      default: tgt_sec = overlay && (int'(addr) < SEC_BYTES);
    endcase
  end
endmodule

// File: rtl/iap_op_timer.sv
module iap_op_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          finish,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign busy   = (cnt != '0);
  assign finish = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt <= load;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  // R6
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/iap_flash_bank.sv
module iap_flash_bank #(
  parameter int BYTES  = 64,
  parameter int SECTOR = 16,
  localparam int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          sect_erase,
  input  logic          bank_erase,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [BYTES];

  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < BYTES; i++) begin
        if (bank_erase || (sect_erase && (i / SECTOR == int'(waddr) / SECTOR)))
          mem[i] <= 8'hFF;
        else if (prog && (i == int'(waddr)))
          mem[i] <= mem[i] & wdata;
      end
    end
  end
endmodule

// File: rtl/iap_flash_ctrl.sv
module iap_flash_ctrl
  import iap_pkg::*;
#(
  parameter int MAIN_BYTES = 256,
  parameter int SEC_BYTES  = 64,
  parameter int SECTOR     = 16,
  parameter int PROG_LAT   = 4,
  parameter int SECT_LAT   = 10,
  parameter int BLK_LAT    = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr_en,
  input  logic [2:0]                    reg_addr,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    reg_rdata,
  input  logic [1:0]                    exec_src,
  input  logic                          lock_main,
  input  logic                          lock_sec,
  input  logic                          ext_int_pin,
  output logic                          int1_out,
  output logic                          flash_busy,
  input  logic                          rd_sel_sec,
  input  logic [$clog2(MAIN_BYTES)-1:0] rd_addr,
  output logic [7:0]                    rd_data,
  output logic                          rd_fail
);
  localparam int MAW  = $clog2(MAIN_BYTES);
  localparam int SAW  = $clog2(SEC_BYTES);
  localparam int MAXL = (PROG_LAT > SECT_LAT) ? ((PROG_LAT > BLK_LAT) ? PROG_LAT : BLK_LAT)
                                              : ((SECT_LAT > BLK_LAT) ? SECT_LAT : BLK_LAT);
  localparam int CW   = $clog2(MAXL + 1);

  logic [7:0]    addr_lo, addr_hi, data_r;
  logic          cfg_en, cfg_ovl, err, int_mode;
  op_kind_e      op_r;
  logic          tgt_r;
  logic [MAW-1:0] waddr_r;
  logic [7:0]    wdata_r;

  logic          tgt_sec, locked, cmd_wr, op_ok, start;
  logic          busy, finish, done;
  logic [CW-1:0] load;
  logic [7:0]    main_q, sec_q;

  iap_target_resolve #(.SEC_BYTES(SEC_BYTES)) u_res (
    .src(exec_src), .overlay(cfg_ovl), .addr({addr_hi, addr_lo}), .tgt_sec(tgt_sec));

  assign cmd_wr = reg_wr_en && (reg_addr == RA_CMD);
  assign op_ok  = (reg_wdata[6:0] == OP_PROG) || (reg_wdata[6:0] == OP_SERA) ||
                  (reg_wdata[6:0] == OP_BERA);
  assign locked = tgt_sec ? lock_sec : lock_main;
  assign start  = cmd_wr && !busy && cfg_en && !locked && op_ok;

  always_comb begin
    case (reg_wdata[1:0])
      2'd1:    load = CW'(PROG_LAT);
      2'd2:    load = CW'(SECT_LAT);
      default: load = CW'(BLK_LAT);
    endcase
  end

  iap_op_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .busy(busy), .finish(finish), .done(done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo  <= '0;
      addr_hi  <= '0;
      data_r   <= '0;
      cfg_en   <= 1'b0;
      cfg_ovl  <= 1'b0;
      err      <= 1'b0;
      int_mode <= 1'b0;
      op_r     <= K_PROG;
      tgt_r    <= 1'b0;
      waddr_r  <= '0;
      wdata_r  <= '0;
    end else begin
      if (reg_wr_en) begin
        case (reg_addr)
          RA_ALO:  addr_lo <= reg_wdata;
          RA_AHI:  addr_hi <= reg_wdata;
          RA_DAT:  data_r  <= reg_wdata;
          RA_CFG:  begin cfg_en <= reg_wdata[7]; cfg_ovl <= reg_wdata[0]; end
          RA_STAT: if (reg_wdata[1]) err <= 1'b0;
          default: ;
        endcase
      end
      if (cmd_wr && busy) err <= 1'b1;
      if (start) begin
        op_r     <= op_kind_e'(reg_wdata[1:0]);
        tgt_r    <= tgt_sec;
        waddr_r  <= addr_lo[MAW-1:0];
        wdata_r  <= data_r;
        int_mode <= reg_wdata[7];
      end
    end
  end

  iap_flash_bank #(.BYTES(MAIN_BYTES), .SECTOR(SECTOR)) u_main (
    .clk(clk), .rst_n(rst_n),
    .prog(finish && !tgt_r && op_r == K_PROG),
    .sect_erase(finish && !tgt_r && op_r == K_SERA),
    .bank_erase(finish && !tgt_r && op_r == K_BERA),
    .waddr(waddr_r), .wdata(wdata_r), .raddr(rd_addr), .rdata(main_q));

  iap_flash_bank #(.BYTES(SEC_BYTES), .SECTOR(SECTOR)) u_sec (
    .clk(clk), .rst_n(rst_n),
    .prog(finish && tgt_r && op_r == K_PROG),
    .sect_erase(finish && tgt_r && op_r == K_SERA),
    .bank_erase(finish && tgt_r && op_r == K_BERA),
    .waddr(waddr_r[SAW-1:0]), .wdata(wdata_r), .raddr(rd_addr[SAW-1:0]), .rdata(sec_q));

  assign rd_fail    = busy && (rd_sel_sec == tgt_r);
  assign rd_data    = rd_fail ? 8'h00 : (rd_sel_sec ? sec_q : main_q);
  assign flash_busy = busy;
  assign int1_out   = int_mode ? done : ext_int_pin;

  always_comb begin
    case (reg_addr)
      RA_ALO:  reg_rdata = addr_lo;
      RA_AHI:  reg_rdata = addr_hi;
      RA_DAT:  reg_rdata = data_r;
      RA_CFG:  reg_rdata = {cfg_en, 6'b0, cfg_ovl};
      RA_STAT: reg_rdata = {6'b0, err, busy};
      default: reg_rdata = 8'h00;
    endcase
  end

  // R11
  busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> err);
  // R1
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_en));
  // R4
  main_src_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && exec_src == 2'd0) |=> tgt_r);
  // R4
  sec_src_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && exec_src == 2'd1) |=> !tgt_r);
  // R3
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(locked));
endmodule

// File: tb/iap_flash_ctrl_bench.sv
module iap_flash_ctrl_bench;
  localparam int MB = 256, SB = 64, SEC = 16, PL = 4, SL = 10, BL = 20;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0; logic [2:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [1:0] exec_src = 0;
  logic lock_main = 0, lock_sec = 0, ext_int_pin = 0;
  logic int1_out, flash_busy;
  logic rd_sel_sec = 0; logic [7:0] rd_addr = 0;
  logic [7:0] rd_data; logic rd_fail;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  iap_flash_ctrl #(.MAIN_BYTES(MB), .SEC_BYTES(SB), .SECTOR(SEC),
    .PROG_LAT(PL), .SECT_LAT(SL), .BLK_LAT(BL)) u_iap_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exec_src(exec_src),
    .lock_main(lock_main), .lock_sec(lock_sec), .ext_int_pin(ext_int_pin),
    .int1_out(int1_out), .flash_busy(flash_busy), .rd_sel_sec(rd_sel_sec),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_fail(rd_fail));

  // behavioural reference model
  int m_main [MB];
  int m_sec [SB];
  int m_cnt, m_op, m_tgt, m_a, m_d, m_alo, m_ahi, m_dat;
  bit m_en, m_ovl, m_err, m_done, m_imode;

  task automatic m_apply();
    if (m_op == 1) begin
      if (m_tgt == 1) m_sec[m_a % SB] = m_sec[m_a % SB] & m_d;
      else m_main[m_a % MB] = m_main[m_a % MB] & m_d;
    end else begin
      int lo, hi;
      int sz = (m_tgt == 1) ? SB : MB;
      if (m_op == 2) begin lo = ((m_a % sz) / SEC) * SEC; hi = lo + SEC; end
      else begin lo = 0; hi = sz; end
      for (int i = lo; i < hi; i++)
        if (m_tgt == 1) m_sec[i] = 255; else m_main[i] = 255;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_err = 0; m_done = 0; m_imode = 0; m_en = 0; m_ovl = 0;
      m_alo = 0; m_ahi = 0; m_dat = 0; m_op = 1; m_tgt = 0; m_a = 0; m_d = 0;
      for (int i = 0; i < MB; i++) m_main[i] = 255;
      for (int i = 0; i < SB; i++) m_sec[i] = 255;
    end else begin
      bit was_busy;
      was_busy = (m_cnt > 0);
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin m_apply(); m_done = 1; end
      end
      if (reg_wr_en) begin
        case (reg_addr)
          0: begin
            int code, tgt, adr;
            code = reg_wdata & 127;
            adr = m_ahi * 256 + m_alo;
            if (exec_src == 0) tgt = 1;
            else if (exec_src == 1) tgt = 0;
            else tgt = (m_ovl && adr < SB) ? 1 : 0;
            if (was_busy) m_err = 1;
            else if (m_en && code >= 1 && code <= 3 &&
                     !((tgt == 1) ? lock_sec : lock_main)) begin
              m_op = code; m_tgt = tgt; m_a = m_alo; m_d = m_dat;
              m_imode = reg_wdata[7];
              m_cnt = (code == 1) ? PL : (code == 2) ? SL : BL;
            end
          end
          1: m_alo = reg_wdata;
          2: m_ahi = reg_wdata;
          3: m_dat = reg_wdata;
          4: begin m_en = reg_wdata[7]; m_ovl = reg_wdata[0]; end
          5: if (reg_wdata[1]) m_err = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison of R6 busy and R9 interrupt line
  always @(negedge clk) begin
    #2;
    if (rst_n && !ended) begin
      chk("R6 busy", flash_busy, m_cnt > 0);
      chk("R9 int1", int1_out, m_imode ? m_done : ext_int_pin);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); reg_wr_en = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rdchk(string req, bit sel, int a);
    @(negedge clk); rd_sel_sec = sel; rd_addr = 8'(a); #3;
    if (m_cnt > 0 && m_tgt == int'(sel)) begin
      chk(req, rd_fail, 1); chk(req, rd_data, 0);
    end else begin
      chk(req, rd_fail, 0); chk(req, rd_data, sel ? m_sec[a % SB] : m_main[a]);
    end
  endtask

  task automatic regchk(string req, int a, int exp);
    @(negedge clk); reg_addr = 3'(a); #3; chk(req, reg_rdata, exp);
  endtask

  task automatic idle();
    for (int i = 0; i < 100 && flash_busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(int src, int ahi, int alo, int dat, int cmd);
    exec_src = 2'(src);
    wr(2, ahi); wr(1, alo); wr(3, dat); wr(0, cmd);
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1; n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi_cycles, pulses;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    regchk("R13 status", 5, 0); regchk("R13 cfg", 4, 0);
    rdchk("R13 main", 0, 7); rdchk("R13 sec", 1, 9);
    // R1 disabled
    op(0, 0, 5, 8'h0F, 1);
    repeat (6) @(negedge clk);
    chk("R1 no busy", flash_busy, 0); rdchk("R1 sec", 1, 5);
    // R2 other registers do not start
    wr(4, 8'h80); wr(1, 3); wr(3, 0); wr(5, 2);
    chk("R2 no busy", flash_busy, 0);
    // R4 main -> secondary, R6 program length
    op(0, 0, 5, 8'hA5, 1);
    hi_cycles = 0;
    while (flash_busy) begin hi_cycles++; @(negedge clk); end
    chk("R6 prog cycles", hi_cycles, PL);
    @(negedge clk);
    rdchk("R4 sec written", 1, 5); rdchk("R4 main intact", 0, 5);
    // R7 AND
    op(0, 0, 5, 8'h5A, 1); idle();
    rdchk("R7 and", 1, 5); chk("R7 value", m_sec[5], 0);
    // R4 secondary -> main
    op(1, 0, 8'h10, 8'h3C, 1); idle(); rdchk("R4 main written", 0, 16);
    // R5 external
    op(2, 0, 3, 8'h11, 1); idle(); rdchk("R5 no ovl main", 0, 3);
    wr(4, 8'h81);
    op(3, 0, 3, 8'h22, 1); idle(); rdchk("R5 ovl sec", 1, 3);
    op(2, 0, 8'h50, 8'h44, 1); idle(); rdchk("R5 ovl high main", 0, 8'h50);
    op(2, 1, 2, 8'h66, 1); idle(); rdchk("R5 high byte main", 0, 2);
    // R3 lock
    lock_sec = 1;
    op(0, 0, 8'h20, 8'h00, 1);
    repeat (6) @(negedge clk);
    chk("R3 locked busy", flash_busy, 0); rdchk("R3 locked", 1, 8'h20);
    lock_sec = 0;
    op(0, 0, 8'h20, 8'h77, 1); idle(); rdchk("R3 unlocked", 1, 8'h20);
    // R12 bad code
    op(0, 0, 8'h21, 8'h00, 5);
    chk("R12 bad code", flash_busy, 0); rdchk("R12 no change", 1, 8'h21);
    // R10 read during sector erase, R8 sector range
    op(0, 0, 4, 0, 2);
    rdchk("R10 busy bank", 1, 5); rdchk("R10 other bank", 0, 16);
    // R11 command while busy
    wr(0, 1);
    regchk("R11 err set", 5, 3);
    idle();
    rdchk("R8 sector erased", 1, 5); rdchk("R8 outside kept", 1, 8'h20);
    wr(5, 2); regchk("R11 err cleared", 5, 0);
    // R8 bank erase of main
    op(1, 0, 0, 0, 3);
    hi_cycles = 0;
    while (flash_busy) begin hi_cycles++; @(negedge clk); end
    chk("R6 bank erase cycles", hi_cycles, BL);
    rdchk("R8 bank erased", 0, 16); rdchk("R8 bank erased b", 0, 8'h50);
    rdchk("R8 other bank kept", 1, 8'h20);
    // R9 interrupt mode
    ext_int_pin = 1;
    op(0, 0, 8'h30, 8'h0F, 8'h81);
    pulses = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); #3; if (int1_out) pulses++; end
    chk("R9 one pulse", pulses, 1);
    op(0, 0, 8'h31, 8'h0F, 1); idle();
    #3; chk("R9 pin follows", int1_out, 1);
    ext_int_pin = 0; #1; chk("R9 pin low", int1_out, 0);
    repeat (3) @(negedge clk);
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule